// File: doc/BRIEF.md
# Dual-Clock Serial Port Global Control Register

This block is the top-level reset-enable register of a serial audio port. Software writes it through a simple bus port in the bus clock domain. The register has two five-bit control groups, one for the transmit section and one for the receive section. Each group drives the enables of five sub-blocks: the frame sync generator, the state machine, the serializers, the high-frequency clock divider and the bit clock divider. A zero holds a sub-block in reset.

A group takes effect only after it has been carried into its own serial clock domain, which is the transmit clock for the transmit group and the receive clock for the receive group. Each crossing uses a chain of synchronizer flops. Reads do not return the value that was written. They return the value that has been latched in the serial domain, brought back to the bus clock through a second synchronizer. Software therefore polls the register until the written bits come back, and that tells it the change has reached the serial side. If a serial clock is stopped, its group keeps its old value, and the readback shows that old value.

Top module: `sport_global_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `txEnable`, `rxEnable` and the register readback are all zero. Every sub-block is then held in reset.
- R2: A write to address `CTL_ADDR` (default 0x44) puts data bits 12:8 on `txEnable[4:0]` within a few transmit clock edges. Bit 12 is the frame sync generator, bit 11 the state machine, bit 10 the serializers, bit 9 the high-frequency clock divider and bit 8 the bit clock divider.
- R3: The same write puts data bits 4:0 on `rxEnable[4:0]` within a few receive clock edges. The five controls are in the same order as in R2.
- R4: Data bits 31:13 and 7:5 are reserved. They always read as zero, and writing ones to them changes no output.
- R5: A read returns the serial-domain latched copy. Bits 12:8 come from the transmit domain and bits 4:0 from the receive domain. A read made directly after a write still shows the previous latched value.
- R6: While a serial clock is stopped, that section's enables and its readback field keep their old values. The other section still updates. When the clock resumes, the pending value is taken.
- R7: A write to any address other than `CTL_ADDR` changes nothing. A read of any other address returns zero.
- R8: Read data appears on `busRdata` one bus clock after the read request. It holds that value until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset for all three domains |
| txClk | input | 1 | Transmit serial clock |
| rxClk | input | 1 | Receive serial clock |
| busValid | input | 1 | Bus request valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Request address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| txEnable | output | 5 | Transmit sub-block enables (frame sync, state machine, serializers, high-freq divider, bit divider) |
| rxEnable | output | 5 | Receive sub-block enables, same order |

## Verification
The main function is swept over all 32 transmit patterns. Each is paired with the complementary receive pattern and with the reserved bits set to ones, so a swapped or mis-ordered bit, a group routed to the wrong section, or a reserved bit leaking into the readback each give a wrong value. A read made directly after a write separates a design that returns the latched copy from one that echoes the written data. Stopping only the receive clock shows that each group is latched in its own domain, and that the readback follows the latched value rather than the written one. Writes and reads to a foreign address, and a write with no read after it, check address decode and read-data holding.

// File: rtl/sport_ctl_pkg.sv
package sport_ctl_pkg;
  localparam int DATA_W  = 32;
  localparam int FIELD_W = 5;
  localparam int TX_LSB  = 8;
  localparam int RX_LSB  = 0;
  localparam logic [DATA_W-1:0] WRITE_MASK =
    (DATA_W'((1 << FIELD_W) - 1) << TX_LSB) | (DATA_W'((1 << FIELD_W) - 1) << RX_LSB);

  typedef struct packed {
    logic hit;   // address matches the control register
    logic wrEn;  // capture write data into the shadow copy
    logic rdEn;  // update the read data register
  } ctlStrobes_t;
endpackage

// File: rtl/sport_ctl_sync.sv
module sport_ctl_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             dstClk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge dstClk or negedge rstN) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge dstClk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign qOut = chain[STAGES-1];
endmodule

// File: rtl/sport_ctl_decode.sv
module sport_ctl_decode
  import sport_ctl_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'('h44)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobes_t       strobes
);
  logic addrHit;

  always_comb begin
    addrHit      = (busAddr == CTL_ADDR);
    strobes.hit  = addrHit;
    strobes.wrEn = busValid && busWrite && addrHit;
    strobes.rdEn = busValid && !busWrite;
  end

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrEn, strobes.rdEn}));
endmodule

// File: rtl/sport_ctl_datapath.sv
module sport_ctl_datapath
  import sport_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txClk,
  input  logic               rxClk,
  input  ctlStrobes_t        strobes,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [FIELD_W-1:0] txEnable,
  output logic [FIELD_W-1:0] rxEnable
);
  logic [DATA_W-1:0]  shadow;
  logic [FIELD_W-1:0] txBack;
  logic [FIELD_W-1:0] rxBack;
  logic [DATA_W-1:0]  readWord;

  // bus-domain shadow copy of the writable bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shadow <= '0;
    else if (strobes.wrEn) shadow <= busWdata & WRITE_MASK;
  end

  // forward crossings into each serial domain
  sport_ctl_sync #(.WIDTH(FIELD_W), .STAGES(SYNC_STAGES)) i_txFwd (
    .dstClk(txClk), .rstN(rstN),
    .dIn(shadow[TX_LSB +: FIELD_W]), .qOut(txEnable));

  sport_ctl_sync #(.WIDTH(FIELD_W), .STAGES(SYNC_STAGES)) i_rxFwd (
    .dstClk(rxClk), .rstN(rstN),
    .dIn(shadow[RX_LSB +: FIELD_W]), .qOut(rxEnable));

  // return crossings of the latched copies into the bus domain
  sport_ctl_sync #(.WIDTH(FIELD_W), .STAGES(SYNC_STAGES)) i_txBack (
    .dstClk(clk), .rstN(rstN), .dIn(txEnable), .qOut(txBack));

  sport_ctl_sync #(.WIDTH(FIELD_W), .STAGES(SYNC_STAGES)) i_rxBack (
    .dstClk(clk), .rstN(rstN), .dIn(rxEnable), .qOut(rxBack));

  always_comb begin
    readWord = '0;
    readWord[TX_LSB +: FIELD_W] = txBack;
    readWord[RX_LSB +: FIELD_W] = rxBack;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             busRdata <= '0;
    else if (strobes.rdEn) busRdata <= strobes.hit ? readWord : '0;
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrEn |=> $stable(shadow));

  // R4
  shadow_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shadow & ~WRITE_MASK) == '0);

  // R4
  rdata_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & ~WRITE_MASK) == '0);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> $stable(busRdata));
endmodule

// File: rtl/sport_global_ctl.sv
module sport_global_ctl
  import sport_ctl_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR    = ADDR_W'('h44),
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txClk,
  input  logic              rxClk,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [4:0]        txEnable,
  output logic [4:0]        rxEnable
);
  ctlStrobes_t strobes;

  sport_ctl_decode #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) i_decode (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .strobes(strobes));

  sport_ctl_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rstN(rstN), .txClk(txClk), .rxClk(rxClk),
    .strobes(strobes), .busWdata(busWdata), .busRdata(busRdata),
    .txEnable(txEnable), .rxEnable(rxEnable));
endmodule

// File: tb/test_sport_global_ctl.sv
module test_sport_global_ctl;
  localparam logic [7:0] REG_ADDR = 8'h44;

  logic clk = 0, txClk = 0, rxClk = 0, rstN = 0;
  logic txRun = 1, rxRun = 1;
  logic busValid = 0, busWrite = 0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [4:0]  txEnable, rxEnable;
  int total = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always begin #15; if (txRun) txClk = ~txClk; end
  always begin #23; if (rxRun) rxClk = ~rxClk; end

  sport_global_ctl i_sport_global_ctl (
    .clk(clk), .rstN(rstN), .txClk(txClk), .rxClk(rxClk),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .txEnable(txEnable), .rxEnable(rxEnable));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic busRd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busValid = 0;
    d = busRdata;
  endtask

  task automatic settle();
    repeat (24) @(negedge clk);
  endtask

  function automatic logic [31:0] regWord(logic [4:0] tx, logic [4:0] rx);
    return {19'b0, tx, 3'b0, rx};
  endfunction

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 tx in reset", {27'b0, txEnable}, 32'h0);
    check("R1 rx in reset", {27'b0, rxEnable}, 32'h0);
    rstN = 1;
    repeat (4) @(negedge clk);
    busRd(REG_ADDR, rd);
    check("R1 readback after reset", rd, 32'h0);

    // R2 R3 R4 sweep: every tx pattern, complementary rx, reserved bits ones
    for (int v = 0; v < 32; v++) begin
      logic [4:0] tx = 5'(v);
      logic [4:0] rx = 5'(31 - v);
      busWr(REG_ADDR, {19'h7FFFF, tx, 3'b111, rx});
      settle();
      check("R2 txEnable", {27'b0, txEnable}, {27'b0, tx});
      check("R3 rxEnable", {27'b0, rxEnable}, {27'b0, rx});
      busRd(REG_ADDR, rd);
      check("R4 readback reserved zero", rd, regWord(tx, rx));
    end

    // R5 read straight after a write returns the previous latched copy
    busWr(REG_ADDR, regWord(5'h0A, 5'h05));
    settle();
    busWr(REG_ADDR, regWord(5'h15, 5'h1A));
    busRd(REG_ADDR, rd);
    check("R5 immediate read old", rd, regWord(5'h0A, 5'h05));
    settle();
    busRd(REG_ADDR, rd);
    check("R5 settled read new", rd, regWord(5'h15, 5'h1A));

    // R6 stopped receive clock holds receive bits
    rxRun = 0;
    settle();
    busWr(REG_ADDR, regWord(5'h03, 5'h1C));
    repeat (40) @(negedge clk);
    check("R6 rx held", {27'b0, rxEnable}, 32'h1A);
    check("R6 tx moves", {27'b0, txEnable}, 32'h03);
    busRd(REG_ADDR, rd);
    check("R6 readback mixed", rd, regWord(5'h03, 5'h1A));
    rxRun = 1;
    settle();
    check("R6 rx resumes", {27'b0, rxEnable}, 32'h1C);
    busRd(REG_ADDR, rd);
    check("R6 readback resumed", rd, regWord(5'h03, 5'h1C));

    // R7 foreign address
    busWr(8'h40, regWord(5'h1F, 5'h1F));
    settle();
    check("R7 tx unchanged", {27'b0, txEnable}, 32'h03);
    check("R7 rx unchanged", {27'b0, rxEnable}, 32'h1C);
    busRd(8'h48, rd);
    check("R7 foreign read zero", rd, 32'h0);

    // R8 read data holds without a read
    busRd(REG_ADDR, held);
    busWr(REG_ADDR, regWord(5'h11, 5'h0E));
    settle();
    check("R8 rdata held", busRdata, held);
    busRd(REG_ADDR, rd);
    check("R8 rdata updated", rd, regWord(5'h11, 5'h0E));

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule